// File: doc/BRIEF.md
# Pair-Matching Compressed Line Placer

This block decides where lines go inside one set of an 8-way cache in which each 64-byte data way holds either a single uncompressed line or up to two compressed lines sharing the same storage. Each way has two slots, and each slot carries a valid bit, a tag and a size field. The cache presents the metadata of the currently indexed set, together with the set number. A single placer serves every set of the cache.

Two operations are offered. A lookup compares a tag against every slot of every way at once and reports the hit way and slot one cycle later. An insert of a compressed line of a given byte size returns a way, a slot and an eviction mask two cycles later. The placer first tries to fit the line next to an existing partner without evicting anything, choosing the way whose remaining space is the tightest fit. If no way fits, it evicts one line, or failing that two lines, starting from a per-set round-robin position. Moving the data is left to the surrounding cache.

Top module: `pair_line_placer`

## Requirements
- R1: After reset, lookDone, hitValid and insDone are 0, evictMask is all zero, and every set's round-robin pointer is way 0.
- R2: A lookup request is answered on the next clock edge with lookDone=1. hitValid=1 is reported when a valid slot's tag equals lookupTag, and hitWay and hitSlot then name that slot. Slot index i = 2*way + slot in the metaValid, metaTag and metaSize vectors, with field i at bits [i*W +: W].
- R3: Invalid slots never hit. Slot 1 of an uncompressed way never hits, even when its valid bit is set.
- R4: An insert request produces a one-cycle insDone pulse exactly two clock edges later, and not earlier.
- R5: A way is compressed when slot 0's size field is nonzero. Its free space is 64 minus the sizes of its valid slots. An insert fits a compressed way that has an invalid slot when the free space is at least the insert size, so an exact fit is accepted. Among the fitting ways, the one with the least free space is chosen, with evictMask zero and insOk=1.
- R6: When fitting ways tie on free space, the lowest-numbered way is chosen.
- R7: A way whose slot-0 size is 0 (uncompressed) is never chosen for insertion and never evicted, whether valid or not.
- R8: In a fitting way, the new line goes into the lowest-numbered invalid slot.
- R9: When nothing fits, a single valid slot is evicted if the way's free space plus that slot's size reaches the insert size. Compressed ways are scanned from the set's round-robin pointer upward with wrap-around, and slot 0 is tried before slot 1. The new line takes the evicted slot.
- R10: When no single eviction suffices, both slots of the first compressed way in that scan order that holds two valid lines are evicted, and the new line goes to slot 0.
- R11: After any eviction, the pointer of the set named by setIdx moves to the way after the victim, wrapping around. The other sets' pointers are unchanged.
- R12: When no compressed way exists, insDone=1 with insOk=0 and evictMask all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| setIdx | input | 6 | Index of the set whose metadata is presented |
| metaValid | input | 16 | Valid bit per slot, index 2*way+slot |
| metaTag | input | 320 | 20-bit tag per slot |
| metaSize | input | 112 | 7-bit size per slot (0 = uncompressed, 64 = empty compressed slot) |
| lookupReq | input | 1 | Start a tag lookup |
| lookupTag | input | 20 | Tag to look up |
| insertReq | input | 1 | Start a compressed-line insertion |
| insertSize | input | 7 | Compressed size in bytes, 1 to 64 |
| lookDone | output | 1 | Lookup result valid |
| hitValid | output | 1 | Lookup found a matching slot |
| hitWay | output | 3 | Way of the hit |
| hitSlot | output | 1 | Slot of the hit |
| insDone | output | 1 | Insert result valid |
| insOk | output | 1 | A location was found |
| insWay | output | 3 | Way receiving the new line |
| insSlot | output | 1 | Slot receiving the new line |
| evictMask | output | 16 | Slots to evict, index 2*way+slot |

## Verification
The bench targets the size arithmetic at its edges. An exact 64-byte fill must be accepted, and a design comparing with a strict inequality would refuse it and evict. Ties and best-fit ordering are driven by ways with equal and unequal free space, so a first-fit or highest-way design picks a visibly different way. Uncompressed ways are given set slot-1 valid bits and matching tags, so a design that ignores the zero-size marker reports false hits or evicts a whole uncompressed line. Repeated evictions on one set and then another show whether the pointer advances per set and whether slot 1 is chosen only when slot 0 cannot make room.

// File: rtl/pmp_pkg.sv
package pmp_pkg;
  localparam int LINE_BYTES = 64;
  localparam int SIZE_W = $clog2(LINE_BYTES) + 1;

  typedef logic [SIZE_W-1:0] size_t;
  typedef logic [SIZE_W:0] space_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capIns;
    logic capLook;
  } strobe_t;

  // per-way summary captured for the insert decision
  typedef struct packed {
    logic comp;
    logic [1:0] vld;
    logic hasHole;
    logic holeSlot;
    space_t free;
    size_t sz0;
    size_t sz1;
  } wayInfo_t;
endpackage

// File: rtl/placer_datapath.sv
module placer_datapath
  import pmp_pkg::*;
#(
  parameter int WAYS = 8,
  parameter int TAG_W = 20,
  localparam int SLOTS = 2 * WAYS,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobe_t                stb,
  input  logic [SLOTS-1:0]       metaValid,
  input  logic [SLOTS*TAG_W-1:0] metaTag,
  input  logic [SLOTS*SIZE_W-1:0] metaSize,
  input  logic [TAG_W-1:0]       lookupTag,
  input  size_t                  insertSize,
  output wayInfo_t [WAYS-1:0]    infoQ,
  output size_t                  needQ,
  output logic                   hitValid,
  output logic [WAY_W-1:0]       hitWay,
  output logic                   hitSlot
);
  wayInfo_t [WAYS-1:0] infoD;
  logic [SLOTS-1:0] slotMatch;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    size_t s0, s1;
    logic v0, v1, comp;
    space_t used;
    assign s0 = metaSize[(2*w)*SIZE_W +: SIZE_W];
    assign s1 = metaSize[(2*w+1)*SIZE_W +: SIZE_W];
    assign v0 = metaValid[2*w];
    assign v1 = metaValid[2*w+1];
    assign comp = (s0 != '0);
    assign used = (v0 ? space_t'(s0) : '0) + (v1 ? space_t'(s1) : '0);
    assign infoD[w] = '{comp: comp, vld: {v1, v0}, hasHole: !(v0 && v1),
                        holeSlot: v0, free: space_t'(LINE_BYTES) - used,
                        sz0: s0, sz1: s1};
    // slot 1 of an uncompressed way holds nothing
    assign slotMatch[2*w]   = v0 && (metaTag[(2*w)*TAG_W +: TAG_W] == lookupTag);
    assign slotMatch[2*w+1] = v1 && comp && (metaTag[(2*w+1)*TAG_W +: TAG_W] == lookupTag);
  end

  logic hitD;
  logic [WAY_W-1:0] hitWayD;
  logic hitSlotD;
  always_comb begin
    hitD = 1'b0;
    hitWayD = '0;
    hitSlotD = 1'b0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (slotMatch[i]) begin
        hitD = 1'b1;
        hitWayD = WAY_W'(i / 2);
        hitSlotD = i[0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      infoQ <= '0;
      needQ <= '0;
      hitValid <= 1'b0;
      hitWay <= '0;
      hitSlot <= 1'b0;
    end else begin
      if (stb.capIns) begin
        infoQ <= infoD;
        needQ <= insertSize;
      end
      hitValid <= stb.capLook && hitD;
      if (stb.capLook) begin
        hitWay <= hitWayD;
        hitSlot <= hitSlotD;
      end
    end
  end

  assert_hit_slot_valid_R3: assert property (@(posedge clk) disable iff (!rstN)
    hitValid |-> ((($past(metaValid) >> {hitWay, hitSlot}) & SLOTS'(1)) != '0));

  assert_hit_needs_request_R2: assert property (@(posedge clk) disable iff (!rstN)
    hitValid |-> $past(stb.capLook));
endmodule

// File: rtl/placer_control.sv
module placer_control
  import pmp_pkg::*;
#(
  parameter int WAYS = 8,
  parameter int SETS = 64,
  localparam int SLOTS = 2 * WAYS,
  localparam int WAY_W = $clog2(WAYS),
  localparam int SET_W = $clog2(SETS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                lookupReq,
  input  logic                insertReq,
  input  logic [SET_W-1:0]    setIdx,
  input  wayInfo_t [WAYS-1:0] infoQ,
  input  size_t               needQ,
  output strobe_t             stb,
  output logic                lookDone,
  output logic                insDone,
  output logic                insOk,
  output logic [WAY_W-1:0]    insWay,
  output logic                insSlot,
  output logic [SLOTS-1:0]    evictMask
);
  logic insPend;
  logic [SET_W-1:0] setQ;
  logic [WAY_W-1:0] rrPtr [SETS];
  logic [WAY_W-1:0] ptr;

  assign stb = '{capIns: insertReq, capLook: lookupReq};
  assign ptr = rrPtr[setQ];

  logic fitFound, oneFound, twoFound;
  logic [WAY_W-1:0] fitWay, oneWay, twoWay;
  logic fitSlot, oneSlot;
  space_t fitFree, need;

  always_comb begin
    int w;
    need = space_t'(needQ);
    fitFound = 1'b0; fitWay = '0; fitSlot = 1'b0; fitFree = '1;
    oneFound = 1'b0; oneWay = '0; oneSlot = 1'b0;
    twoFound = 1'b0; twoWay = '0;
    for (int k = 0; k < WAYS; k++) begin
      if (infoQ[k].comp && infoQ[k].hasHole && infoQ[k].free >= need &&
          (!fitFound || infoQ[k].free < fitFree)) begin
        fitFound = 1'b1;
        fitWay = WAY_W'(k);
        fitSlot = infoQ[k].holeSlot;
        fitFree = infoQ[k].free;
      end
    end
    for (int k = 0; k < WAYS; k++) begin
      w = (int'(ptr) + k) % WAYS;
      if (infoQ[w].comp) begin
        if (!oneFound && infoQ[w].vld[0] &&
            infoQ[w].free + space_t'(infoQ[w].sz0) >= need) begin
          oneFound = 1'b1; oneWay = WAY_W'(w); oneSlot = 1'b0;
        end else if (!oneFound && infoQ[w].vld[1] &&
                     infoQ[w].free + space_t'(infoQ[w].sz1) >= need) begin
          oneFound = 1'b1; oneWay = WAY_W'(w); oneSlot = 1'b1;
        end
        if (!twoFound && infoQ[w].vld == 2'b11) begin
          twoFound = 1'b1; twoWay = WAY_W'(w);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      insPend <= 1'b0;
      setQ <= '0;
      lookDone <= 1'b0;
      insDone <= 1'b0;
      insOk <= 1'b0;
      insWay <= '0;
      insSlot <= 1'b0;
      evictMask <= '0;
      for (int s = 0; s < SETS; s++) rrPtr[s] <= '0;
    end else begin
      insPend <= insertReq;
      lookDone <= lookupReq;
      if (insertReq) setQ <= setIdx;
      insDone <= insPend;
      evictMask <= '0;
      if (insPend) begin
        insOk <= fitFound || oneFound || twoFound;
        if (fitFound) begin
          insWay <= fitWay; insSlot <= fitSlot;
        end else if (oneFound) begin
          insWay <= oneWay; insSlot <= oneSlot;
          evictMask <= SLOTS'(1) << {oneWay, oneSlot};
          rrPtr[setQ] <= WAY_W'((int'(oneWay) + 1) % WAYS);
        end else if (twoFound) begin
          insWay <= twoWay; insSlot <= 1'b0;
          evictMask <= SLOTS'(3) << {twoWay, 1'b0};
          rrPtr[setQ] <= WAY_W'((int'(twoWay) + 1) % WAYS);
        end else begin
          insWay <= '0; insSlot <= 1'b0;
        end
      end
    end
  end

  assert_ins_latency_R4: assert property (@(posedge clk) disable iff (!rstN)
    insDone |-> $past(insertReq, 2));

  assert_look_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    lookDone |-> $past(lookupReq));

  assert_fail_no_evict_R12: assert property (@(posedge clk) disable iff (!rstN)
    (insDone && !insOk) |-> (evictMask == '0));

  assert_evict_count_R9: assert property (@(posedge clk) disable iff (!rstN)
    $countones(evictMask) <= 2);

  assert_pair_same_way_R10: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(evictMask) == 2) |-> (((evictMask >> {insWay, 1'b0}) & SLOTS'(3)) == SLOTS'(3)));

  assert_evict_only_on_done_R11: assert property (@(posedge clk) disable iff (!rstN)
    (evictMask != '0) |-> (insDone && insOk));
endmodule

// File: rtl/pair_line_placer.sv
module pair_line_placer
  import pmp_pkg::*;
#(
  parameter int WAYS = 8,
  parameter int SETS = 64,
  parameter int TAG_W = 20,
  localparam int SLOTS = 2 * WAYS,
  localparam int WAY_W = $clog2(WAYS),
  localparam int SET_W = $clog2(SETS)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [SET_W-1:0]        setIdx,
  input  logic [SLOTS-1:0]        metaValid,
  input  logic [SLOTS*TAG_W-1:0]  metaTag,
  input  logic [SLOTS*SIZE_W-1:0] metaSize,
  input  logic                    lookupReq,
  input  logic [TAG_W-1:0]        lookupTag,
  input  logic                    insertReq,
  input  logic [SIZE_W-1:0]       insertSize,
  output logic                    lookDone,
  output logic                    hitValid,
  output logic [WAY_W-1:0]        hitWay,
  output logic                    hitSlot,
  output logic                    insDone,
  output logic                    insOk,
  output logic [WAY_W-1:0]        insWay,
  output logic                    insSlot,
  output logic [SLOTS-1:0]        evictMask
);
  strobe_t stb;
  wayInfo_t [WAYS-1:0] infoQ;
  size_t needQ;

  placer_datapath #(.WAYS(WAYS), .TAG_W(TAG_W)) i_datapath (
    .clk(clk), .rstN(rstN), .stb(stb), .metaValid(metaValid), .metaTag(metaTag),
    .metaSize(metaSize), .lookupTag(lookupTag), .insertSize(insertSize),
    .infoQ(infoQ), .needQ(needQ), .hitValid(hitValid), .hitWay(hitWay), .hitSlot(hitSlot)
  );

  placer_control #(.WAYS(WAYS), .SETS(SETS)) i_control (
    .clk(clk), .rstN(rstN), .lookupReq(lookupReq), .insertReq(insertReq),
    .setIdx(setIdx), .infoQ(infoQ), .needQ(needQ), .stb(stb), .lookDone(lookDone),
    .insDone(insDone), .insOk(insOk), .insWay(insWay), .insSlot(insSlot),
    .evictMask(evictMask)
  );

  assert_hit_with_done_R2: assert property (@(posedge clk) disable iff (!rstN)
    hitValid |-> lookDone);
endmodule

// File: tb/test_pair_line_placer.sv
module test_pair_line_placer;
  localparam int WAYS = 8, SETS = 64, TAG_W = 20, SIZE_W = 7;
  localparam int SLOTS = 2 * WAYS;

  logic clk = 1'b0, rstN = 1'b0;
  logic [5:0] setIdx = '0;
  logic [SLOTS-1:0] metaValid = '0;
  logic [SLOTS*TAG_W-1:0] metaTag = '0;
  logic [SLOTS*SIZE_W-1:0] metaSize = '0;
  logic lookupReq = 1'b0, insertReq = 1'b0;
  logic [TAG_W-1:0] lookupTag = '0;
  logic [SIZE_W-1:0] insertSize = '0;
  logic lookDone, hitValid, hitSlot, insDone, insOk, insSlot;
  logic [2:0] hitWay, insWay;
  logic [SLOTS-1:0] evictMask;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  pair_line_placer i_pair_line_placer (
    .clk(clk), .rstN(rstN), .setIdx(setIdx), .metaValid(metaValid), .metaTag(metaTag),
    .metaSize(metaSize), .lookupReq(lookupReq), .lookupTag(lookupTag),
    .insertReq(insertReq), .insertSize(insertSize), .lookDone(lookDone),
    .hitValid(hitValid), .hitWay(hitWay), .hitSlot(hitSlot), .insDone(insDone),
    .insOk(insOk), .insWay(insWay), .insSlot(insSlot), .evictMask(evictMask)
  );

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic setSlot(int w, int s, logic v, int tag, int size);
    metaValid[2*w+s] = v;
    metaTag[(2*w+s)*TAG_W +: TAG_W] = TAG_W'(tag);
    metaSize[(2*w+s)*SIZE_W +: SIZE_W] = SIZE_W'(size);
  endtask

  // every way uncompressed and valid, so none can take a compressed line
  task automatic fillUncomp();
    for (int w = 0; w < WAYS; w++) begin
      setSlot(w, 0, 1'b1, 'h100 + w, 0);
      setSlot(w, 1, 1'b0, 0, 0);
    end
  endtask

  task automatic doLookup(int tag, int expHit, int expWay, int expSlot, string req);
    lookupTag = TAG_W'(tag);
    lookupReq = 1'b1;
    @(negedge clk);
    lookupReq = 1'b0;
    check(req, "lookDone", lookDone, 1);
    check(req, "hitValid", hitValid, expHit);
    if (expHit != 0) begin
      check(req, "hitWay", hitWay, expWay);
      check(req, "hitSlot", hitSlot, expSlot);
    end
  endtask

  task automatic doInsert(int set, int size, int expOk, int expWay, int expSlot,
                          int expMask, string req);
    setIdx = 6'(set);
    insertSize = SIZE_W'(size);
    insertReq = 1'b1;
    @(negedge clk);
    insertReq = 1'b0;
    check("R4", "insDone early", insDone, 0);
    @(negedge clk);
    check("R4", "insDone", insDone, 1);
    check(req, "insOk", insOk, expOk);
    if (expOk != 0) begin
      check(req, "insWay", insWay, expWay);
      check(req, "insSlot", insSlot, expSlot);
    end
    check(req, "evictMask", int'(evictMask), expMask);
  endtask

  task automatic testReset();
    check("R1", "lookDone", lookDone, 0);
    check("R1", "hitValid", hitValid, 0);
    check("R1", "insDone", insDone, 0);
    check("R1", "evictMask", int'(evictMask), 0);
  endtask

  task automatic testLookup();
    for (int w = 0; w < WAYS; w++) begin
      setSlot(w, 0, 1'b0, 0, 0);
      setSlot(w, 1, 1'b0, 0, 0);
    end
    setSlot(3, 0, 1'b1, 'h55, 0);
    setSlot(3, 1, 1'b1, 'h88, 0);   // slot 1 of an uncompressed way
    setSlot(5, 0, 1'b0, 0, 64);
    setSlot(5, 1, 1'b1, 'h66, 20);
    setSlot(6, 0, 1'b0, 'h77, 64);
    setSlot(6, 1, 1'b0, 0, 64);
    doLookup('h66, 1, 5, 1, "R2");
    doLookup('h55, 1, 3, 0, "R2");
    doLookup('h77, 0, 0, 0, "R3");
    doLookup('h88, 0, 0, 0, "R3");
    doLookup('h0, 0, 0, 0, "R3");
    @(negedge clk);
    check("R2", "lookDone pulse", lookDone, 0);
  endtask

  task automatic testBestFit();
    fillUncomp();
    setSlot(1, 0, 1'b1, 1, 40); setSlot(1, 1, 1'b0, 0, 64);
    setSlot(4, 0, 1'b0, 0, 64); setSlot(4, 1, 1'b1, 2, 30);
    setSlot(6, 0, 1'b0, 0, 64); setSlot(6, 1, 1'b0, 0, 64);
    doInsert(0, 20, 1, 1, 1, 0, "R5");
    doInsert(0, 30, 1, 4, 0, 0, "R8");
    doInsert(0, 24, 1, 1, 1, 0, "R5");  // exact fill to 64
    doInsert(0, 25, 1, 4, 0, 0, "R5");
    doInsert(0, 64, 1, 6, 0, 0, "R5");
  endtask

  task automatic testTie();
    fillUncomp();
    setSlot(2, 0, 1'b1, 1, 32); setSlot(2, 1, 1'b0, 0, 64);
    setSlot(5, 0, 1'b1, 2, 32); setSlot(5, 1, 1'b0, 0, 64);
    setSlot(7, 0, 1'b1, 3, 32); setSlot(7, 1, 1'b0, 0, 64);
    doInsert(0, 10, 1, 2, 1, 0, "R6");
  endtask

  task automatic testUncomp();
    fillUncomp();
    doInsert(0, 8, 0, 0, 0, 0, "R12");
    for (int w = 0; w < WAYS; w++) setSlot(w, 0, 1'b0, 0, 0);
    doInsert(0, 8, 0, 0, 0, 0, "R7");
    setSlot(3, 0, 1'b1, 4, 54); setSlot(3, 1, 1'b0, 0, 64);
    doInsert(0, 10, 1, 3, 1, 0, "R7");
  endtask

  task automatic testSingleEvict();
    fillUncomp();
    setSlot(1, 0, 1'b1, 1, 30); setSlot(1, 1, 1'b1, 2, 30);
    setSlot(2, 0, 1'b1, 3, 50); setSlot(2, 1, 1'b1, 4, 10);
    doInsert(5, 20, 1, 1, 0, 'h4, "R9");
    doInsert(5, 20, 1, 2, 0, 'h10, "R11");
    doInsert(5, 20, 1, 1, 0, 'h4, "R11");   // pointer wrapped past way 7
    doInsert(9, 20, 1, 1, 0, 'h4, "R11");   // other set still at way 0
    setSlot(2, 0, 1'b1, 3, 10); setSlot(2, 1, 1'b1, 4, 50);
    doInsert(9, 40, 1, 2, 1, 'h20, "R9");
  endtask

  task automatic testPairEvict();
    fillUncomp();
    setSlot(1, 0, 1'b1, 1, 30); setSlot(1, 1, 1'b1, 2, 30);
    setSlot(3, 0, 1'b1, 3, 30); setSlot(3, 1, 1'b1, 4, 30);
    doInsert(12, 60, 1, 1, 0, 'hC, "R10");
    doInsert(12, 60, 1, 3, 0, 'hC0, "R10");
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testLookup();
    testBestFit();
    testTie();
    testUncomp();
    testSingleEvict();
    testPairEvict();
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule